// File: doc/BRIEF.md
# Two-level summary interrupt aggregator

This block gathers a parameterised number of raw interrupt lines and reports them to a host through one interrupt output. Lines sit eight to a block, and eight blocks form a master group. The host reads a root register to find which master groups have pending lines. It reads a master register to find the blocks, then the block's latched register to find the lines. Each line has its own trigger type (rising edge, falling edge, active high level or active low level) and its own pair of mask bits.

Per-line access goes through a shared block-select register. Software writes a block number there, and later accesses to the configuration, trigger-type, live-level and latched-status addresses act on that block. A latched line is cleared only by a configuration write. That write also rewrites both mask bits of the line, so software that wants to keep a line masked has to write the mask bits again along with the clear.

Top module: `irq_tree_agg`

## Requirements
- R1: Line n is bit n%8 of block n/8 in every per-block view. The block-select register sits at address 1, holds a full byte and reads back the last value written.
- R2: Master m is read at address 8+m. Its bit j is the pending summary of block 8m+j: the OR of that block's latched bits whose line is unmasked. Blocks past the block count read as zero.
- R3: The root register sits at address 0. Bit 0 always reads 0, and bit m+1 is the OR of the bits of master m.
- R4: Address 4 returns the present input level of the eight lines in the selected block, whatever their latch or mask state. Lines past the line count, and block numbers past the block count, read as zero.
- R5: The configuration register sits at address 2 and its fields are: bit 7 write enable, bit 6 clear, bit 5 rising mask, bit 4 falling mask, bits 2:0 line within the selected block. A write with bit 7 at 0 changes nothing, even when the clear bit is set.
- R6: A line is masked when both of its mask bits are 1. A masked line never latches and adds nothing to any summary. After reset every line is masked and set to rising trigger.
- R7: A write to address 3 sets the trigger type of the line given by bits 6:4 in the selected block. The type goes in bits 1:0: 00 rising, 01 falling, 10 level high, 11 level low. An edge type latches on the clock after the edge is seen. A level type latches on every clock while its level is present.
- R8: A configuration write with bits 7 and 6 set clears the line's latched bit and writes its mask bits in the same cycle. The clear wins over a set in that cycle. A level line whose level is still present latches again on the next clock.
- R9: The host interrupt output is the OR of all master summaries, registered once. It rises one clock after a latched bit sets and falls one clock after the last summary clears.
- R10: Read data is captured on the clock where the read strobe is sampled and holds until the next read. The configuration and type addresses, and all unused addresses, read as zero.
- R11: After reset, read data, the block select, all latched bits and the host interrupt are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rawIn | input | NUM_LINES | Raw interrupt lines, synchronous to clk |
| busAddr | input | ADDR_W | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, valid the cycle after busRd |
| hostIrq | output | 1 | Interrupt to the host |

## Verification
The bench builds the block with 68 lines. That gives nine blocks and two master groups, so root bit 2 comes into play. The last block is only half filled, which lets the bench check that its missing lines read as zero. Block number 9 has no lines and lets the bench check the out-of-range select. Random traffic covers all four trigger types, mask changes, clears with and without write enable, and reads of every address, all compared with a bench model. Directed cases cover a clear that lands on a rising edge and a clear of a level line whose level is still present.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;

  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_HIGH = 2'b10,
    TRIG_LOW  = 2'b11
  } trig_e;

  // Strobes from the bus control to the line datapath
  typedef struct packed {
    logic       cfgWr;
    logic       typeWr;
    logic [2:0] lineSel;
    logic [7:0] data;
  } strobe_t;

  localparam int A_ROOT = 0;
  localparam int A_BSEL = 1;
  localparam int A_CFG  = 2;
  localparam int A_TYPE = 3;
  localparam int A_LIVE = 4;
  localparam int A_LAT  = 5;
  localparam int A_MST0 = 8;

  // Configuration byte fields
  localparam int CF_WE    = 7;
  localparam int CF_CLR   = 6;
  localparam int CF_MRISE = 5;
  localparam int CF_MFALL = 4;

endpackage

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int NUM_MASTERS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWr,
  input  logic                     busRd,
  input  logic [7:0]               busWrData,
  input  logic [7:0]               liveByte,
  input  logic [7:0]               latByte,
  input  logic [NUM_MASTERS*8-1:0] masterBytes,
  input  logic [NUM_MASTERS-1:0]   masterSum,
  output logic [7:0]               blkSel,
  output strobe_t                  st,
  output logic [7:0]               busRdData
);

  logic [7:0] rootByte;
  logic [7:0] rdMux;

  always_comb begin
    st.cfgWr   = busWr && (int'(busAddr) == A_CFG);
    st.typeWr  = busWr && (int'(busAddr) == A_TYPE);
    st.lineSel = (int'(busAddr) == A_TYPE) ? busWrData[6:4] : busWrData[2:0];
    st.data    = busWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blkSel <= '0;
    else if (busWr && (int'(busAddr) == A_BSEL)) blkSel <= busWrData;
  end

  // Root bit 0 is reserved; master m sits at bit m+1
  always_comb begin
    rootByte = '0;
    for (int m = 0; m < NUM_MASTERS; m++) rootByte[m+1] = masterSum[m];
  end

  always_comb begin
    rdMux = '0;
    case (int'(busAddr))
      A_ROOT:  rdMux = rootByte;
      A_BSEL:  rdMux = blkSel;
      A_LIVE:  rdMux = liveByte;
      A_LAT:   rdMux = latByte;
      default: begin
        for (int m = 0; m < NUM_MASTERS; m++)
          if (int'(busAddr) == A_MST0 + m) rdMux = masterBytes[m*8 +: 8];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdData <= '0;
    else if (busRd) busRdData <= rdMux;
  end

endmodule

// File: rtl/irq_tree_dp.sv
module irq_tree_dp
  import irq_tree_pkg::*;
#(
  parameter int NUM_LINES   = 72,
  parameter int NUM_BLOCKS  = 9,
  parameter int NUM_MASTERS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_LINES-1:0]     rawIn,
  input  logic [7:0]               blkSel,
  input  strobe_t                  st,
  output logic [7:0]               liveByte,
  output logic [7:0]               latByte,
  output logic [NUM_MASTERS*8-1:0] masterBytes,
  output logic [NUM_MASTERS-1:0]   masterSum,
  output logic                     hostIrq
);

  localparam int LPAD = NUM_BLOCKS * 8;
  localparam int BPAD = NUM_MASTERS * 8;

  logic [LPAD-1:0] rawPad;
  logic [LPAD-1:0] latPad;
  logic [LPAD-1:0] enPad;
  logic [BPAD-1:0] blockSum;
  logic            unusedCfg;

  assign unusedCfg = ^st.data[3:2];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic  prevIn, maskRise, maskFall, latched, setNow, selHit;
    trig_e trig;

    assign selHit = (blkSel == 8'(i / 8)) && (st.lineSel == 3'(i % 8));

    always_comb begin
      unique case (trig)
        TRIG_RISE: setNow = rawIn[i] && !prevIn;
        TRIG_FALL: setNow = !rawIn[i] && prevIn;
        TRIG_HIGH: setNow = rawIn[i];
        default:   setNow = !rawIn[i];
      endcase
      if (maskRise && maskFall) setNow = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevIn   <= 1'b0;
        maskRise <= 1'b1;
        maskFall <= 1'b1;
        trig     <= TRIG_RISE;
        latched  <= 1'b0;
      end else begin
        prevIn <= rawIn[i];
        if (st.typeWr && selHit) trig <= trig_e'(st.data[1:0]);
        if (st.cfgWr && selHit && st.data[CF_WE]) begin
          maskRise <= st.data[CF_MRISE];
          maskFall <= st.data[CF_MFALL];
        end
        if (st.cfgWr && selHit && st.data[CF_WE] && st.data[CF_CLR]) latched <= 1'b0;
        else if (setNow) latched <= 1'b1;
      end
    end

    assign rawPad[i] = rawIn[i];
    assign latPad[i] = latched;
    assign enPad[i]  = !(maskRise && maskFall);
  end

  if (LPAD > NUM_LINES) begin : g_linePad
    assign rawPad[LPAD-1:NUM_LINES] = '0;
    assign latPad[LPAD-1:NUM_LINES] = '0;
    assign enPad[LPAD-1:NUM_LINES]  = '0;
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_block
    assign blockSum[b] = |(latPad[b*8 +: 8] & enPad[b*8 +: 8]);
  end

  if (BPAD > NUM_BLOCKS) begin : g_blockPad
    assign blockSum[BPAD-1:NUM_BLOCKS] = '0;
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
    assign masterSum[m] = |blockSum[m*8 +: 8];
  end

  assign masterBytes = blockSum;

  always_comb begin
    liveByte = '0;
    latByte  = '0;
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      if (blkSel == 8'(b)) begin
        liveByte = rawPad[b*8 +: 8];
        latByte  = latPad[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostIrq <= 1'b0;
    else hostIrq <= |masterSum;
  end

endmodule

// File: rtl/irq_tree_agg.sv
module irq_tree_agg
  import irq_tree_pkg::*;
#(
  parameter int NUM_LINES = 72,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] rawIn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [7:0]           busWrData,
  output logic [7:0]           busRdData,
  output logic                 hostIrq
);

  localparam int NUM_BLOCKS  = (NUM_LINES + 7) / 8;
  localparam int NUM_MASTERS = (NUM_BLOCKS + 7) / 8;

  strobe_t                  st;
  logic [7:0]               blkSel;
  logic [7:0]               liveByte;
  logic [7:0]               latByte;
  logic [NUM_MASTERS*8-1:0] masterBytes;
  logic [NUM_MASTERS-1:0]   masterSum;

  irq_tree_ctrl #(.ADDR_W(ADDR_W), .NUM_MASTERS(NUM_MASTERS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .liveByte(liveByte), .latByte(latByte),
    .masterBytes(masterBytes), .masterSum(masterSum), .blkSel(blkSel),
    .st(st), .busRdData(busRdData)
  );

  irq_tree_dp #(.NUM_LINES(NUM_LINES), .NUM_BLOCKS(NUM_BLOCKS), .NUM_MASTERS(NUM_MASTERS)) u_dp (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .blkSel(blkSel), .st(st),
    .liveByte(liveByte), .latByte(latByte), .masterBytes(masterBytes),
    .masterSum(masterSum), .hostIrq(hostIrq)
  );

endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk
  import irq_tree_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int NUM_MASTERS = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      busAddr,
  input logic                   busWr,
  input logic                   busRd,
  input logic [7:0]             busWrData,
  input logic [7:0]             busRdData,
  input logic                   hostIrq,
  input logic [NUM_MASTERS-1:0] masterSum,
  input logic [7:0]             blkSel,
  input logic [7:0]             liveByte,
  input logic [7:0]             latByte
);

  p_root_bit0_r3: assert property (@(posedge clk) disable iff (!rstN)
    busRd && (int'(busAddr) == A_ROOT) |=> !busRdData[0]);

  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (masterSum != '0) |=> hostIrq);

  p_irq_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (masterSum == '0) |=> !hostIrq);

  p_bsel_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && (int'(busAddr) == A_BSEL)) |=> $stable(blkSel));

  p_live_view_r4: assert property (@(posedge clk) disable iff (!rstN)
    busRd && (int'(busAddr) == A_LIVE) |=> busRdData == $past(liveByte));

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    busWr && (int'(busAddr) == A_CFG) && busWrData[CF_WE] && busWrData[CF_CLR]
    |=> !latByte[$past(busWrData[2:0])]);

  p_no_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && ((int'(busAddr) == A_CFG) || (int'(busAddr) == A_BSEL)))
    |=> ((~latByte & $past(latByte)) == 8'h00));

endmodule

bind irq_tree_agg irq_tree_chk #(.ADDR_W(ADDR_W), .NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busWrData(busWrData), .busRdData(busRdData), .hostIrq(hostIrq),
  .masterSum(masterSum), .blkSel(blkSel), .liveByte(liveByte), .latByte(latByte)
);

// File: tb/tb_irq_tree_agg.sv
module tb_irq_tree_agg;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 68;
  localparam int NB = (NL + 7) / 8;
  localparam int NM = (NB + 7) / 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] rawIn = '0;
  logic [3:0]    busAddr = '0;
  logic          busWr = 1'b0;
  logic          busRd = 1'b0;
  logic [7:0]    busWrData = '0;
  logic [7:0]    busRdData;
  logic          hostIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // Bench model state
  bit       mLat [NL];
  bit       mMR  [NL];
  bit       mMF  [NL];
  bit [1:0] mTyp [NL];
  bit       mPrev[NL];
  bit [7:0] mBsel;
  bit       mIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_tree_agg #(.NUM_LINES(NL), .ADDR_W(4)) dut (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWrData(busWrData), .busRdData(busRdData), .hostIrq(hostIrq)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit blockSumM(int b);
    bit s = 0;
    for (int k = 0; k < 8; k++) begin
      int n = b * 8 + k;
      if (n < NL && mLat[n] && !(mMR[n] && mMF[n])) s = 1;
    end
    return s;
  endfunction

  function automatic bit [7:0] masterM(int m);
    bit [7:0] v = '0;
    for (int j = 0; j < 8; j++)
      if (m * 8 + j < NB) v[j] = blockSumM(m * 8 + j);
    return v;
  endfunction

  function automatic bit [7:0] expRead(int a);
    bit [7:0] v = '0;
    if (a == 0) begin
      for (int m = 0; m < NM; m++) v[m+1] = |masterM(m);
    end else if (a == 1) v = mBsel;
    else if (a == 4 || a == 5) begin
      for (int k = 0; k < 8; k++) begin
        int n = int'(mBsel) * 8 + k;
        if (int'(mBsel) < NB && n < NL) v[k] = (a == 4) ? rawIn[n] : mLat[n];
      end
    end else if (a >= 8 && a < 8 + NM) v = masterM(a - 8);
    return v;
  endfunction

  function automatic void modelStep();
    bit irqN = 0;
    for (int m = 0; m < NM; m++) if (|masterM(m)) irqN = 1;
    for (int i = 0; i < NL; i++) begin
      bit en = !(mMR[i] && mMF[i]);
      bit s;
      bit cHit, tHit;
      case (mTyp[i])
        2'b00: s = rawIn[i] && !mPrev[i];
        2'b01: s = !rawIn[i] && mPrev[i];
        2'b10: s = rawIn[i];
        default: s = !rawIn[i];
      endcase
      s = s && en;
      cHit = busWr && busAddr == 4'd2 && busWrData[7] && int'(mBsel) == i / 8 && int'(busWrData[2:0]) == i % 8;
      tHit = busWr && busAddr == 4'd3 && int'(mBsel) == i / 8 && int'(busWrData[6:4]) == i % 8;
      if (cHit && busWrData[6]) mLat[i] = 0;
      else if (s) mLat[i] = 1;
      if (cHit) begin mMR[i] = busWrData[5]; mMF[i] = busWrData[4]; end
      if (tHit) mTyp[i] = busWrData[1:0];
      mPrev[i] = rawIn[i];
    end
    if (busWr && busAddr == 4'd1) mBsel = busWrData;
    mIrq = irqN;
  endfunction

  task automatic cyc();
    modelStep();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(int a, bit [7:0] d);
    busAddr = 4'(a); busWrData = d; busWr = 1'b1;
    cyc();
    busWr = 1'b0;
  endtask

  task automatic busReadExp(int a, bit [7:0] e, string tag);
    busAddr = 4'(a); busRd = 1'b1;
    cyc();
    busRd = 1'b0;
    check(busRdData == e, tag, busRdData, e);
  endtask

  task automatic busReadModel(int a, string tag);
    bit [7:0] e = expRead(a);
    busReadExp(a, e, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'd4711);
    for (int i = 0; i < NL; i++) begin
      mLat[i] = 0; mMR[i] = 1; mMF[i] = 1; mTyp[i] = 0; mPrev[i] = 0;
    end
    mBsel = 0; mIrq = 0;
    if (seed == 0) mIrq = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: reset state
    check(busRdData == 8'h00, "R11 rdData", busRdData, 0);
    check(hostIrq == 1'b0, "R11 hostIrq", hostIrq, 0);
    busReadExp(0, 8'h00, "R11 root");
    busReadExp(1, 8'h00, "R11 bsel");
    busReadExp(5, 8'h00, "R11 latched");

    // R6: masked at reset, rising edge ignored
    rawIn[0] = 1'b1; cyc();
    busReadExp(5, 8'h00, "R6 masked line");
    rawIn[0] = 1'b0; cyc();

    // R1 R2 R3 R9: line 10 = block 1 bit 2
    busWrite(1, 8'h01);
    busWrite(2, 8'h82);
    rawIn[10] = 1'b1; cyc();
    busReadExp(5, 8'h04, "R1 latched line10");
    check(hostIrq == 1'b1, "R9 hostIrq set", hostIrq, 1);
    busReadExp(8, 8'h02, "R2 master0");
    busReadExp(0, 8'h02, "R3 root");

    // R8: clear beats a rising edge in the same cycle
    rawIn[10] = 1'b0; cyc();
    busWrite(2, 8'hC2);
    rawIn[10] = 1'b1;
    busWrite(2, 8'hC2);
    busReadExp(5, 8'h00, "R8 clear wins over edge");

    // R7 level high on line 65 (block 8 bit 1, master 1)
    busWrite(1, 8'h08);
    busWrite(3, 8'h12);
    busWrite(2, 8'h81);
    rawIn[65] = 1'b1; cyc();
    busReadExp(5, 8'h02, "R7 level high");
    busReadExp(9, 8'h01, "R2 master1");
    busReadExp(0, 8'h04, "R3 root master1");

    // R5: clear without write enable ignored
    busWrite(2, 8'h41);
    busReadExp(5, 8'h02, "R5 no write enable");

    // R8: level still active re-latches next cycle
    busWrite(2, 8'hC1);
    busReadExp(5, 8'h00, "R8 cleared");
    busReadExp(5, 8'h02, "R8 relatched");

    // R6: clear together with mask keeps it quiet
    busWrite(2, 8'hF1);
    busReadExp(5, 8'h00, "R6 masked clear");
    busReadExp(5, 8'h00, "R6 stays clear");
    check(hostIrq == 1'b0, "R9 hostIrq clear", hostIrq, 0);

    // R4: live levels, partial block
    rawIn[67] = 1'b1;
    busReadExp(4, 8'h0A, "R4 live block8");
    busWrite(1, 8'h09);
    busReadExp(1, 8'h09, "R1 bsel readback");
    busReadExp(4, 8'h00, "R4 out of range live");
    busReadExp(5, 8'h00, "R2 out of range latched");

    // R10: unused and write-only addresses
    busReadExp(6, 8'h00, "R10 addr6");
    busReadExp(2, 8'h00, "R10 cfg addr");
    busReadExp(15, 8'h00, "R10 addr15");

    // R7 falling on line 0, level low on line 3
    busWrite(1, 8'h00);
    busWrite(3, 8'h01);
    busWrite(2, 8'h80);
    rawIn[0] = 1'b1; cyc();
    busReadExp(5, 8'h00, "R7 falling ignores rise");
    rawIn[0] = 1'b0; cyc();
    busReadExp(5, 8'h01, "R7 falling latched");
    busWrite(3, 8'h33);
    busWrite(2, 8'h83);
    cyc();
    busReadExp(5, 8'h09, "R7 level low");

    // Random phase against the bench model
    for (int it = 0; it < 1500; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) begin
        for (int f = 0; f < 3; f++) rawIn[$urandom_range(0, NL-1)] ^= 1'b1;
        cyc();
      end else if (op < 5) begin
        bit [7:0] d = {($urandom_range(0, 9) != 0), 1'($urandom), 2'($urandom), 1'b0, 3'($urandom)};
        if ($urandom_range(0, 3) != 0 && d[5:4] == 2'b11) d[5] = 1'b0;
        busWrite(2, d);
      end else if (op == 5) begin
        busWrite(3, {1'b0, 3'($urandom), 2'b00, 2'($urandom)});
      end else if (op == 6) begin
        busWrite(1, 8'($urandom_range(0, NB)));
      end else begin
        int a = $urandom_range(0, 15);
        busReadModel(a, "R10 random read (R1 R2 R3 R4 R7 R8)");
      end
      check(hostIrq == mIrq, "R9 random hostIrq", hostIrq, mIrq);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule